// File: doc/BRIEF.md
# Spike-Count Action Selector with Graded Reward

This block turns the output activity of a layer of spiking neurons into an action for a pursuit task. It keeps one saturating spike counter per neuron and accumulates counts while a stimulus is applied. When the controller signals that the stimulus window is over, the block picks the neuron with the most spikes as the target column. If several neurons share the highest count, one of them is chosen pseudo-randomly. Together with the winner, the block scores the decision with a reward that falls off linearly with the distance between the chosen column and the ball column, and it moves the paddle one column toward the chosen target.

A controller drives one spike strobe per neuron each cycle, pulses the window-end strobe with the current ball column, and issues the counter-clear command before the next stimulus. The counters are not cleared automatically, so activity carries across windows until the controller clears it. Winner, reward and paddle position are registered. They change only on a window end, which is marked by a one-cycle valid pulse.

Top module: `pursuit_action_unit`

## Requirements
- R1: While reset is asserted and after it is released, the outputs are: winner 0, reward 0, paddle at column 16 (half the neuron count), valid low.
- R2: Each cycle in which a neuron's spike strobe is high adds one to that neuron's count. Counts persist across window ends until a clear.
- R3: A count stops at 255 and does not wrap. Further spikes leave it at 255.
- R4: The clear command sets every count to zero. It takes precedence over a spike strobe in the same cycle.
- R5: On the clock edge that samples the window-end strobe, the winner becomes a neuron whose count is the highest. Counts are taken as they stood before that cycle, so spikes in the window-end cycle only affect later windows. The result appears after that edge.
- R6: When several neurons share the highest count, the winner is one of them, picked pseudo-randomly rather than by fixed priority. Over many windows in which all 32 neurons tie, at least 8 distinct winners appear.
- R7: The reward is an 8-bit unsigned fraction in which 255 means 1.0. With d the absolute difference between the winner and the ball column sampled with the window end, the reward is 255 - 51*d for d below 5, and 0 for d of 5 or more.
- R8: At each window end the paddle moves one column toward the new winner, and does not move if it already equals the winner. Between window ends it does not move.
- R9: The valid output is high for exactly the one cycle after each window-end edge. Winner and reward hold their values between window ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spike_i | input | 32 | One spike strobe per neuron, one count per high cycle |
| win_end_i | input | 1 | Stimulus window is over; select the winner this cycle |
| ball_col_i | input | 5 | Ball column, sampled with win_end_i |
| cnt_clr_i | input | 1 | Clear all spike counters |
| winner_o | output | 5 | Index of the selected neuron (target column) |
| reward_o | output | 8 | Graded reward, 255 = 1.0 |
| paddle_o | output | 5 | Paddle column after the latest step |
| result_vld_o | output | 1 | One-cycle pulse after each window end |

## Verification
Several corner cases are targeted. Saturation is tested with one neuron driven well past 255 against a rival left at 100: a wrapping counter would hand the win to the rival. A clear is issued in the same cycle as spikes, and a spike is placed in the window-end cycle. A design that counts through a clear, or that includes the last-cycle spike in the decision, then widens or shifts the winning set. Long runs of windows in which every count is tied expose a fixed-priority selector, which always returns the same index. Reward is checked on both sides of the ball out to distance 6, and the paddle is driven into column 0 and column 31 to catch steps that overshoot or wrap.

// File: rtl/pursuit_pkg.sv
package pursuit_pkg;
    localparam int unsigned DEF_NEURONS   = 32;
    localparam int unsigned DEF_CNT_W     = 8;
    localparam int unsigned DEF_REW_W     = 8;
    localparam int unsigned DEF_SPAN      = 5;
    localparam int unsigned DEF_LFSR_W    = 16;
    // Galois taps for x^16 + x^14 + x^13 + x^11 + 1 (maximal length)
    localparam logic [15:0] DEF_LFSR_TAPS = 16'hB400;
    localparam logic [15:0] DEF_LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/spike_count_bank.sv
module spike_count_bank #(
    parameter int unsigned N = 32,
    parameter int unsigned W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic [N-1:0]     spike_i,
    output logic [N*W-1:0]   count_o
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] count_d [N];
    logic [W-1:0] count_q [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            count_d[i] = count_q[i];
            if (clr_i) begin
                count_d[i] = '0;
            end else if (spike_i[i] && (count_q[i] != CNT_MAX)) begin
                count_d[i] = count_q[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < N; i++) begin
                count_q[i] <= '0;
            end
        end else begin
            count_q <= count_d;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_flat
        assign count_o[g*W +: W] = count_q[g];
    end
endmodule

// File: rtl/argmax_pick.sv
module argmax_pick #(
    parameter int unsigned    N    = 32,
    parameter int unsigned    W    = 8,
    parameter int unsigned    RW   = 16,
    parameter logic [RW-1:0]  TAPS = 16'hB400,
    parameter logic [RW-1:0]  SEED = 16'hACE1
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [N*W-1:0]        count_i,
    output logic [$clog2(N)-1:0]  pick_o
);
    localparam int unsigned IDX_W = $clog2(N);
    localparam int unsigned NW    = IDX_W + 1;
    localparam int unsigned PW    = RW + NW;

    logic [RW-1:0] lfsr_d, lfsr_q;
    logic [W-1:0]  top_val;
    logic [N-1:0]  tied;
    logic [NW-1:0] n_tied, k_sel, run;
    logic [PW-1:0] scaled;

    always_comb begin
        lfsr_d = {1'b0, lfsr_q[RW-1:1]} ^ (lfsr_q[0] ? TAPS : '0);

        top_val = '0;
        for (int i = 0; i < N; i++) begin
            if (count_i[i*W +: W] > top_val) begin
                top_val = count_i[i*W +: W];
            end
        end

        n_tied = '0;
        for (int i = 0; i < N; i++) begin
            tied[i] = (count_i[i*W +: W] == top_val);
            n_tied  = n_tied + {{(NW-1){1'b0}}, tied[i]};
        end

        // scale the random word onto [0, n_tied)
        scaled = PW'(lfsr_q) * PW'(n_tied);
        k_sel  = scaled[RW +: NW];

        pick_o = '0;
        run    = '0;
        for (int i = 0; i < N; i++) begin
            if (tied[i]) begin
                if (run == k_sel) begin
                    pick_o = IDX_W'(i);
                end
                run = run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lfsr_q <= SEED;
        end else begin
            lfsr_q <= lfsr_d;
        end
    end
endmodule

// File: rtl/reward_paddle.sv
module reward_paddle #(
    parameter int unsigned N     = 32,
    parameter int unsigned REW_W = 8,
    parameter int unsigned SPAN  = 5
) (
    input  logic [$clog2(N)-1:0] target_i,
    input  logic [$clog2(N)-1:0] ball_i,
    input  logic [$clog2(N)-1:0] paddle_i,
    output logic [REW_W-1:0]     reward_o,
    output logic [$clog2(N)-1:0] paddle_o
);
    localparam int unsigned IDX_W = $clog2(N);
    localparam int unsigned FULL  = (1 << REW_W) - 1;
    localparam int unsigned STEP  = FULL / SPAN;

    logic [IDX_W-1:0] diff;
    logic [31:0]      dist32;

    always_comb begin
        diff   = (target_i >= ball_i) ? (target_i - ball_i) : (ball_i - target_i);
        dist32 = 32'(diff);
        if (dist32 >= SPAN) begin
            reward_o = '0;
        end else begin
            reward_o = REW_W'(FULL - STEP * dist32);
        end

        if (paddle_i < target_i) begin
            paddle_o = paddle_i + 1'b1;
        end else if (paddle_i > target_i) begin
            paddle_o = paddle_i - 1'b1;
        end else begin
            paddle_o = paddle_i;
        end
    end
endmodule

// File: rtl/pursuit_action_unit.sv
module pursuit_action_unit #(
    parameter int unsigned                          NEURONS = pursuit_pkg::DEF_NEURONS,
    parameter int unsigned                          CNT_W   = pursuit_pkg::DEF_CNT_W,
    parameter int unsigned                          REW_W   = pursuit_pkg::DEF_REW_W,
    parameter int unsigned                          SPAN    = pursuit_pkg::DEF_SPAN,
    parameter int unsigned                          LFSR_W  = pursuit_pkg::DEF_LFSR_W,
    parameter logic [pursuit_pkg::DEF_LFSR_W-1:0]   TAPS    = pursuit_pkg::DEF_LFSR_TAPS,
    parameter logic [pursuit_pkg::DEF_LFSR_W-1:0]   SEED    = pursuit_pkg::DEF_LFSR_SEED
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [NEURONS-1:0]          spike_i,
    input  logic                        win_end_i,
    input  logic [$clog2(NEURONS)-1:0]  ball_col_i,
    input  logic                        cnt_clr_i,
    output logic [$clog2(NEURONS)-1:0]  winner_o,
    output logic [REW_W-1:0]            reward_o,
    output logic [$clog2(NEURONS)-1:0]  paddle_o,
    output logic                        result_vld_o
);
    localparam int unsigned      IDX_W       = $clog2(NEURONS);
    localparam logic [IDX_W-1:0] PADDLE_HOME = IDX_W'(NEURONS / 2);

    typedef struct packed {
        logic [IDX_W-1:0] winner;
        logic [REW_W-1:0] reward;
        logic [IDX_W-1:0] paddle;
        logic             vld;
    } act_state_t;

    act_state_t st_d, st_q;

    logic [NEURONS*CNT_W-1:0] counts;
    logic [IDX_W-1:0]         pick;
    logic [REW_W-1:0]         rew_next;
    logic [IDX_W-1:0]         pad_next;

    spike_count_bank #(.N(NEURONS), .W(CNT_W)) u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (cnt_clr_i),
        .spike_i (spike_i),
        .count_o (counts)
    );

    argmax_pick #(.N(NEURONS), .W(CNT_W), .RW(LFSR_W), .TAPS(TAPS), .SEED(SEED)) u_pick (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .count_i (counts),
        .pick_o  (pick)
    );

    reward_paddle #(.N(NEURONS), .REW_W(REW_W), .SPAN(SPAN)) u_score (
        .target_i (pick),
        .ball_i   (ball_col_i),
        .paddle_i (st_q.paddle),
        .reward_o (rew_next),
        .paddle_o (pad_next)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (win_end_i) begin
            st_d.winner = pick;
            st_d.reward = rew_next;
            st_d.paddle = pad_next;
            st_d.vld    = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.winner <= '0;
            st_q.reward <= '0;
            st_q.paddle <= PADDLE_HOME;
            st_q.vld    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign winner_o     = st_q.winner;
    assign reward_o     = st_q.reward;
    assign paddle_o     = st_q.paddle;
    assign result_vld_o = st_q.vld;
endmodule

// File: rtl/pursuit_action_chk.sv
module pursuit_action_chk #(
    parameter int unsigned IDX_W = 5,
    parameter int unsigned REW_W = 8,
    parameter int unsigned SPAN  = 5
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             win_end_i,
    input logic [IDX_W-1:0] ball_col_i,
    input logic [IDX_W-1:0] winner_o,
    input logic [REW_W-1:0] reward_o,
    input logic [IDX_W-1:0] paddle_o,
    input logic             result_vld_o
);
    localparam logic [REW_W-1:0] FULL = '1;

    logic [IDX_W-1:0] ball_q;
    logic [IDX_W-1:0] gap;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ball_q <= '0;
        end else if (win_end_i) begin
            ball_q <= ball_col_i;
        end
    end

    always_comb begin
        gap = (winner_o >= ball_q) ? (winner_o - ball_q) : (ball_q - winner_o);
    end

    // R9
    vld_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_end_i |=> result_vld_o);

    // R9
    vld_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !win_end_i |=> !result_vld_o);

    // R9
    hold_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !win_end_i |=> ($stable(winner_o) && $stable(reward_o) && $stable(paddle_o)));

    // R8
    paddle_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_end_i |=> ((paddle_o == $past(paddle_o)) == (winner_o == $past(paddle_o))));

    // R8
    paddle_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_end_i |=> (!(winner_o > $past(paddle_o)) || (paddle_o == $past(paddle_o) + 1'b1)));

    // R8
    paddle_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_end_i |=> (!(winner_o < $past(paddle_o)) || (paddle_o == $past(paddle_o) - 1'b1)));

    // R7
    full_reward_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_end_i |=> ((winner_o == $past(ball_col_i)) == (reward_o == FULL)));

    // R7
    zero_reward_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        result_vld_o |-> ((reward_o == '0) == (32'(gap) >= SPAN)));
endmodule

bind pursuit_action_unit pursuit_action_chk #(
    .IDX_W (IDX_W),
    .REW_W (REW_W),
    .SPAN  (SPAN)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .win_end_i    (win_end_i),
    .ball_col_i   (ball_col_i),
    .winner_o     (winner_o),
    .reward_o     (reward_o),
    .paddle_o     (paddle_o),
    .result_vld_o (result_vld_o)
);

// File: tb/pursuit_action_unit_bench.sv
module pursuit_action_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] spike = '0;
    logic        win_end = 1'b0;
    logic [4:0]  ball = '0;
    logic        clr = 1'b0;
    logic [4:0]  winner;
    logic [7:0]  reward;
    logic [4:0]  paddle;
    logic        result_vld;

    int n_chk = 0;
    int n_fail = 0;
    bit running = 1'b0;
    bit done = 1'b0;
    bit collect = 1'b0;
    logic [31:0] seen = '0;

    // behavioural reference state
    int          m_cnt [32];
    logic [31:0] m_tie = '0;
    int          m_ball = 0;
    bit          m_pend = 1'b0;
    int          m_paddle = 16;
    int          m_winner = 0;
    int          m_reward = 0;
    int          m_mx = 0;
    int          dd = 0;
    string       tag;

    always #5 clk = ~clk;

    pursuit_action_unit u_pursuit_action_unit (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .spike_i      (spike),
        .win_end_i    (win_end),
        .ball_col_i   (ball),
        .cnt_clr_i    (clr),
        .winner_o     (winner),
        .reward_o     (reward),
        .paddle_o     (paddle),
        .result_vld_o (result_vld)
    );

    task automatic chk(input bit ok, input string t, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", t, act, exp, $time);
        end
    endtask

    // model: evaluates with pre-edge counts, then updates counts (R2, R3, R4, R5)
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) m_cnt[i] = 0;
            m_pend = 1'b0;
            m_paddle = 16;
            m_winner = 0;
            m_reward = 0;
        end else begin
            m_pend = win_end;
            if (win_end) begin
                m_mx = 0;
                for (int i = 0; i < 32; i++) if (m_cnt[i] > m_mx) m_mx = m_cnt[i];
                for (int i = 0; i < 32; i++) m_tie[i] = (m_cnt[i] == m_mx);
                m_ball = int'(ball);
            end
            for (int i = 0; i < 32; i++) begin
                if (clr) m_cnt[i] = 0;
                else if (spike[i] && m_cnt[i] < 255) m_cnt[i] = m_cnt[i] + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && running && !done) begin
            chk(result_vld == m_pend, "R9 valid", int'(result_vld), int'(m_pend));
            if (m_pend) begin
                tag = ($countones(m_tie) > 1) ? "R6 winner in tied set" : "R5 unique winner";
                chk(m_tie[winner] == 1'b1, tag, int'(winner), int'(m_tie[31:0] & -m_tie));
                m_winner = int'(winner);
                dd = m_winner - m_ball;
                if (dd < 0) dd = -dd;
                m_reward = (dd >= 5) ? 0 : 255 - 51 * dd;
                if (m_paddle < m_winner) m_paddle++;
                else if (m_paddle > m_winner) m_paddle--;
                chk(int'(reward) == m_reward, "R7 reward", int'(reward), m_reward);
                chk(int'(paddle) == m_paddle, "R8 paddle step", int'(paddle), m_paddle);
                if (collect && $countones(m_tie) == 32) seen[winner] = 1'b1;
            end else begin
                chk(int'(winner) == m_winner, "R9 winner hold", int'(winner), m_winner);
                chk(int'(reward) == m_reward, "R9 reward hold", int'(reward), m_reward);
                chk(int'(paddle) == m_paddle, "R8 paddle hold", int'(paddle), m_paddle);
            end
        end
    end

    task automatic tick(input logic [31:0] sp, input bit we, input bit cl, input int bc);
        @(negedge clk);
        spike = sp;
        win_end = we;
        clr = cl;
        ball = 5'(bc);
    endtask

    task automatic burst(input int n, input int idx);
        for (int i = 0; i < n; i++) tick(32'h1 << idx, 1'b0, 1'b0, 0);
    endtask

    task automatic clear_all();
        tick('0, 1'b0, 1'b1, 0);
    endtask

    task automatic window(input int bc);
        tick('0, 1'b1, 1'b0, bc);
        tick('0, 1'b0, 1'b0, bc);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        // R1: reset state, during and after reset
        repeat (3) @(negedge clk);
        chk(winner == 5'd0, "R1 winner", int'(winner), 0);
        chk(reward == 8'd0, "R1 reward", int'(reward), 0);
        chk(paddle == 5'd16, "R1 paddle", int'(paddle), 16);
        chk(result_vld == 1'b0, "R1 valid", int'(result_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(paddle == 5'd16, "R1 paddle after release", int'(paddle), 16);
        running = 1'b1;

        // R2 R5: unique maximum with overlapping strobes
        clear_all();
        burst(2, 10);
        tick(32'h0010_0400, 1'b0, 1'b0, 0);
        tick(32'h0010_0400, 1'b0, 1'b0, 0);
        window(10);

        // R7: distances on both sides of the ball
        for (int d = -6; d <= 6; d++) begin
            clear_all();
            burst(3, 12);
            window(12 + d);
        end

        // R3: saturation instead of wrap
        clear_all();
        burst(300, 4);
        burst(100, 7);
        window(4);
        clear_all();
        burst(300, 4);
        burst(260, 7);
        window(6);

        // R4: clear wins over same-cycle spikes
        for (int r = 0; r < 4; r++) begin
            clear_all();
            burst(5, 3);
            tick(32'h0000_0088, 1'b0, 1'b1, 0);
            burst(1, 9);
            window(9);
        end

        // R5 R2: spike in the window-end cycle counts only for later windows
        clear_all();
        burst(3, 5);
        burst(2, 6);
        tick(32'h0000_0040, 1'b1, 1'b0, 5);
        tick('0, 1'b0, 1'b0, 5);
        window(6);

        // R8: paddle into both edges
        clear_all();
        burst(1, 0);
        for (int r = 0; r < 20; r++) window(0);
        clear_all();
        burst(1, 31);
        for (int r = 0; r < 36; r++) window(31);

        // R6: fully tied windows, varied spacing
        collect = 1'b1;
        for (int r = 0; r < 64; r++) begin
            clear_all();
            for (int g = 0; g < (r % 7); g++) tick('0, 1'b0, 1'b0, 0);
            window(r % 32);
        end
        collect = 1'b0;
        repeat (2) @(negedge clk);
        chk($countones(seen) >= 8, "R6 distinct tie winners", $countones(seen), 8);

        finish_run();
    end
endmodule